// File: doc/BRIEF.md
# Tag-Wakeup Reservation Station

This block is the scheduling pool that sits in front of one functional unit in an out-of-order core. The rename stage inserts an instruction carrying an opcode, a destination tag, and two source operands. Each source arrives either as a finished value or as the tag of the instruction that will produce it. Every occupied entry watches a single result broadcast bus that carries a tag and a value. When a waiting source sees its tag on the bus, it latches the value.

An entry whose two sources are both present is a candidate for issue. A select step picks one candidate per cycle and hands its opcode, destination tag and operand values to the functional unit. The entry is released on the edge where the unit accepts it. Because issue follows operand readiness rather than arrival order, an independent instruction can leave before an older one that is still waiting on a slow producer.

Each entry is a three-state machine:
- `SLOT_FREE` holds nothing.
- `SLOT_WAIT` holds an instruction with at least one missing source.
- `SLOT_READY` holds an instruction with both sources present.

The transitions are:
- alloc-wait (FREE to WAIT)
- alloc-ready (FREE to READY)
- wake (WAIT to READY)
- issue (READY to FREE)
- flush (any state to FREE)

Top module: `rs_wakeup_station`

## Requirements
- R1: After reset no entry is occupied, so `ins_ready` is 1 and `iss_valid` is 0.
- R2: `ins_ready` is 0 whenever all ENTRIES slots are occupied. An `ins_valid` pulse while `ins_ready` is 0 is dropped, and that instruction never reaches the issue port.
- R3: A source inserted with its ready flag set to 1 keeps the supplied value, and that value is presented unchanged on its issue operand (`iss_v1` for source 1, `iss_v2` for source 2).
- R4: On a cycle with `cdb_valid`=1, a waiting source whose stored tag equals `cdb_tag` captures `cdb_val` and becomes ready at the next edge. A broadcast with a different tag, or with `cdb_valid`=0, leaves the source waiting.
- R5: An entry is offered for issue only when both of its sources are ready. The offer is visible on the cycle after the edge at which the last source became ready.
- R6: A source inserted as waiting is captured as ready at insertion if a valid broadcast with its tag is on the bus in that same cycle.
- R7: At most one instruction is offered per cycle. When several entries are ready, the lowest-indexed one is offered, and new instructions fill the lowest-indexed free slot.
- R8: While `fu_ready` is 0, the offered entry is kept and remains a candidate. An instruction is removed only on an edge where `iss_valid` and `fu_ready` are both 1.
- R9: Issue follows readiness, not insertion order: a later independent instruction issues while an earlier one is still waiting. The earlier one issues once its source arrives.
- R10: `flush`=1 empties every slot at the next edge. During the flush cycle, `ins_ready` and `iss_valid` are both 0 and any insert is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots |
| ins_valid | input | 1 | Insert request |
| ins_op | input | OP_W | Opcode of inserted instruction |
| ins_dst | input | TAG_W | Destination tag of inserted instruction |
| ins_s1_rdy | input | 1 | Source 1 carries a value (1) or a tag (0) |
| ins_s1_tag | input | TAG_W | Producer tag of source 1 |
| ins_s1_val | input | DATA_W | Value of source 1 |
| ins_s2_rdy | input | 1 | Source 2 carries a value (1) or a tag (0) |
| ins_s2_tag | input | TAG_W | Producer tag of source 2 |
| ins_s2_val | input | DATA_W | Value of source 2 |
| ins_ready | output | 1 | A free slot exists; insert accepted |
| cdb_valid | input | 1 | Broadcast bus carries a result |
| cdb_tag | input | TAG_W | Tag of broadcast result |
| cdb_val | input | DATA_W | Value of broadcast result |
| iss_valid | output | 1 | An instruction is offered to the functional unit |
| iss_op | output | OP_W | Opcode of offered instruction |
| iss_dst | output | TAG_W | Destination tag of offered instruction |
| iss_v1 | output | DATA_W | Source 1 value of offered instruction |
| iss_v2 | output | DATA_W | Source 2 value of offered instruction |
| fu_ready | input | 1 | Functional unit accepts the offer |

## Verification
The embedded properties are checked on every cycle:
- each slot is allocated only from `SLOT_FREE` and issued only from `SLOT_READY`
- a matching broadcast is latched with its value, and a captured value then holds
- at most one slot is granted issue
- a stalled offer persists
- a full pool refuses inserts, and a flush leaves no offer

Only the bench scenarios can show the remaining properties. These are:
- the ordering relations: lowest-index choice and an independent instruction passing a waiting one
- same-cycle capture at insertion
- that a refused insert never surfaces later

The bench shows these by comparing every cycle against an arithmetic model across directed cases and a long pseudo-random sweep with a small tag space.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_t;

endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_rdy,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_val,
    output logic              rdy_nxt,
    output logic [DATA_W-1:0] val
);

    logic              rdy_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;
    logic [TAG_W-1:0]  tag_d;
    logic [DATA_W-1:0] val_d;
    logic              hit_ld;
    logic              hit_q;

    assign hit_ld = cdb_valid && (cdb_tag == ld_tag);
    assign hit_q  = cdb_valid && (cdb_tag == tag_q);

    always_comb begin
        rdy_nxt = rdy_q;
        tag_d   = tag_q;
        val_d   = val_q;
        if (load) begin
            tag_d = ld_tag;
            if (ld_rdy) begin
                rdy_nxt = 1'b1;
                val_d   = ld_val;
            end else if (hit_ld) begin
                rdy_nxt = 1'b1;
                val_d   = cdb_val;
            end else begin
                rdy_nxt = 1'b0;
                val_d   = '0;
            end
        end else if (!rdy_q && hit_q) begin
            rdy_nxt = 1'b1;
            val_d   = cdb_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            tag_q <= '0;
            val_q <= '0;
        end else begin
            rdy_q <= rdy_nxt;
            tag_q <= tag_d;
            val_q <= val_d;
        end
    end

    assign val = val_q;

    // R4: a matching broadcast is latched with its value
    assert_tag_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !rdy_q && hit_q) |=> (rdy_q && val_q == $past(cdb_val)));

    // R4: once captured, a value is not disturbed by later broadcasts
    assert_value_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rdy_q) |=> $stable(val_q));

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            grant[i] = req[i] && !seen;
            seen     = seen | req[i];
        end
        any = seen;
    end

endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic              issue_go,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [TAG_W-1:0]  ld_dst,
    input  logic              ld_r1,
    input  logic [TAG_W-1:0]  ld_t1,
    input  logic [DATA_W-1:0] ld_v1,
    input  logic              ld_r2,
    input  logic [TAG_W-1:0]  ld_t2,
    input  logic [DATA_W-1:0] ld_v2,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_val,
    output logic              is_free,
    output logic              is_ready,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] v1,
    output logic [DATA_W-1:0] v2
);

    slot_state_t       state_q;
    slot_state_t       state_d;
    logic              r1_nxt;
    logic              r2_nxt;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q;

    rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src1 (
        .clk(clk), .rst_n(rst_n), .load(alloc),
        .ld_rdy(ld_r1), .ld_tag(ld_t1), .ld_val(ld_v1),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
        .rdy_nxt(r1_nxt), .val(v1)
    );

    rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src2 (
        .clk(clk), .rst_n(rst_n), .load(alloc),
        .ld_rdy(ld_r2), .ld_tag(ld_t2), .ld_val(ld_v2),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
        .rdy_nxt(r2_nxt), .val(v2)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = SLOT_FREE;
        end else begin
            unique case (state_q)
                SLOT_FREE:  if (alloc) state_d = (r1_nxt && r2_nxt) ? SLOT_READY : SLOT_WAIT;
                SLOT_WAIT:  if (r1_nxt && r2_nxt) state_d = SLOT_READY;
                SLOT_READY: if (issue_go) state_d = SLOT_FREE;
                default:    state_d = SLOT_FREE;
            endcase
        end
    end

    // state and payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            op_q    <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            if (alloc) begin
                op_q  <= ld_op;
                dst_q <= ld_dst;
            end
        end
    end

    // outputs
    always_comb begin
        is_free  = (state_q == SLOT_FREE);
        is_ready = (state_q == SLOT_READY);
        op       = op_q;
        dst      = dst_q;
    end

    assert_alloc_only_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (state_q == SLOT_FREE));

    assert_issue_only_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |-> (state_q == SLOT_READY));

    assert_flush_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == SLOT_FREE));

endmodule

// File: rtl/rs_wakeup_station.sv
module rs_wakeup_station #(
    parameter int ENTRIES = 4,
    parameter int OP_W    = 4,
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ins_valid,
    input  logic [OP_W-1:0]   ins_op,
    input  logic [TAG_W-1:0]  ins_dst,
    input  logic              ins_s1_rdy,
    input  logic [TAG_W-1:0]  ins_s1_tag,
    input  logic [DATA_W-1:0] ins_s1_val,
    input  logic              ins_s2_rdy,
    input  logic [TAG_W-1:0]  ins_s2_tag,
    input  logic [DATA_W-1:0] ins_s2_val,
    output logic              ins_ready,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_val,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_v1,
    output logic [DATA_W-1:0] iss_v2,
    input  logic              fu_ready
);

    logic [ENTRIES-1:0] free_req;
    logic [ENTRIES-1:0] free_grant;
    logic               free_any;
    logic [ENTRIES-1:0] rdy_req;
    logic [ENTRIES-1:0] rdy_grant;
    logic               rdy_any;
    logic [ENTRIES-1:0] alloc;
    logic [ENTRIES-1:0] issue_go;
    logic               accept;

    logic [OP_W-1:0]   slot_op  [ENTRIES];
    logic [TAG_W-1:0]  slot_dst [ENTRIES];
    logic [DATA_W-1:0] slot_v1  [ENTRIES];
    logic [DATA_W-1:0] slot_v2  [ENTRIES];

    rs_pick #(.N(ENTRIES)) u_free_pick (
        .req(free_req), .grant(free_grant), .any(free_any)
    );

    rs_pick #(.N(ENTRIES)) u_issue_pick (
        .req(rdy_req), .grant(rdy_grant), .any(rdy_any)
    );

    assign ins_ready = free_any && !flush;
    assign accept    = ins_valid && ins_ready;
    assign iss_valid = rdy_any && !flush;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            assign alloc[g]    = accept && free_grant[g];
            assign issue_go[g] = rdy_grant[g] && iss_valid && fu_ready;

            rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
                .clk(clk), .rst_n(rst_n), .flush(flush),
                .alloc(alloc[g]), .issue_go(issue_go[g]),
                .ld_op(ins_op), .ld_dst(ins_dst),
                .ld_r1(ins_s1_rdy), .ld_t1(ins_s1_tag), .ld_v1(ins_s1_val),
                .ld_r2(ins_s2_rdy), .ld_t2(ins_s2_tag), .ld_v2(ins_s2_val),
                .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
                .is_free(free_req[g]), .is_ready(rdy_req[g]),
                .op(slot_op[g]), .dst(slot_dst[g]),
                .v1(slot_v1[g]), .v2(slot_v2[g])
            );
        end
    endgenerate

    // one-hot issue mux
    always_comb begin
        iss_op  = '0;
        iss_dst = '0;
        iss_v1  = '0;
        iss_v2  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rdy_grant[i]) begin
                iss_op  = slot_op[i];
                iss_dst = slot_dst[i];
                iss_v1  = slot_v1[i];
                iss_v2  = slot_v2[i];
            end
        end
    end

    assert_single_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_go));

    assert_full_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (free_req == '0) |-> !ins_ready);

    assert_stall_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !fu_ready && !flush) |=> (iss_valid || flush));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !iss_valid);

endmodule

// File: tb/rs_wakeup_station_tb.sv
module rs_wakeup_station_tb;

    localparam int N  = 4;
    localparam int OW = 4;
    localparam int TW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, flush, ins_valid, ins_s1_rdy, ins_s2_rdy, ins_ready;
    logic [OW-1:0] ins_op, iss_op;
    logic [TW-1:0] ins_dst, ins_s1_tag, ins_s2_tag, cdb_tag, iss_dst;
    logic [DW-1:0] ins_s1_val, ins_s2_val, cdb_val, iss_v1, iss_v2;
    logic          cdb_valid, iss_valid, fu_ready;

    rs_wakeup_station #(.ENTRIES(N), .OP_W(OW), .TAG_W(TW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst),
        .ins_s1_rdy(ins_s1_rdy), .ins_s1_tag(ins_s1_tag), .ins_s1_val(ins_s1_val),
        .ins_s2_rdy(ins_s2_rdy), .ins_s2_tag(ins_s2_tag), .ins_s2_val(ins_s2_val),
        .ins_ready(ins_ready),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_v1(iss_v1), .iss_v2(iss_v2), .fu_ready(fu_ready)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model
    bit            m_v  [N];
    bit            m_r1 [N];
    bit            m_r2 [N];
    logic [OW-1:0] m_op [N];
    logic [TW-1:0] m_dst[N];
    logic [TW-1:0] m_t1 [N];
    logic [TW-1:0] m_t2 [N];
    logic [DW-1:0] m_v1 [N];
    logic [DW-1:0] m_v2 [N];

    function automatic int m_free();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return -1;
    endfunction

    function automatic int m_sel();
        for (int i = 0; i < N; i++) if (m_v[i] && m_r1[i] && m_r2[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        int s;
        #1;
        if (rst_n) begin
            chk("R2 ins_ready", ins_ready, (m_free() >= 0) && !flush);
            s = m_sel();
            chk("R5 iss_valid", iss_valid, (s >= 0) && !flush);
            if ((s >= 0) && !flush) begin
                chk("R7 iss_op",  iss_op,  m_op[s]);
                chk("R7 iss_dst", iss_dst, m_dst[s]);
                chk("R3 iss_v1",  iss_v1,  m_v1[s]);
                chk("R3 iss_v2",  iss_v2,  m_v2[s]);
            end
        end
    endtask

    task automatic clk_edge();
        int f, s;
        f = m_free();
        s = m_sel();
        @(posedge clk);
        if (!rst_n || flush) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && !m_r1[i] && cdb_valid && cdb_tag == m_t1[i]) begin
                    m_r1[i] = 1'b1; m_v1[i] = cdb_val;
                end
                if (m_v[i] && !m_r2[i] && cdb_valid && cdb_tag == m_t2[i]) begin
                    m_r2[i] = 1'b1; m_v2[i] = cdb_val;
                end
            end
            if (ins_valid && f >= 0) begin
                m_v[f] = 1'b1; m_op[f] = ins_op; m_dst[f] = ins_dst;
                m_t1[f] = ins_s1_tag; m_t2[f] = ins_s2_tag;
                if (ins_s1_rdy) begin m_r1[f] = 1'b1; m_v1[f] = ins_s1_val; end
                else if (cdb_valid && cdb_tag == ins_s1_tag) begin m_r1[f] = 1'b1; m_v1[f] = cdb_val; end
                else begin m_r1[f] = 1'b0; m_v1[f] = '0; end
                if (ins_s2_rdy) begin m_r2[f] = 1'b1; m_v2[f] = ins_s2_val; end
                else if (cdb_valid && cdb_tag == ins_s2_tag) begin m_r2[f] = 1'b1; m_v2[f] = cdb_val; end
                else begin m_r2[f] = 1'b0; m_v2[f] = '0; end
            end
            if (s >= 0 && fu_ready) m_v[s] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic step();
        settle();
        clk_edge();
    endtask

    task automatic idle();
        flush = 0; ins_valid = 0; ins_op = '0; ins_dst = '0;
        ins_s1_rdy = 0; ins_s1_tag = '0; ins_s1_val = '0;
        ins_s2_rdy = 0; ins_s2_tag = '0; ins_s2_val = '0;
        cdb_valid = 0; cdb_tag = '0; cdb_val = '0; fu_ready = 1;
    endtask

    task automatic put(input logic [OW-1:0] op, input logic [TW-1:0] dst,
                       input logic r1, input logic [TW-1:0] t1, input logic [DW-1:0] v1,
                       input logic r2, input logic [TW-1:0] t2, input logic [DW-1:0] v2);
        ins_valid = 1; ins_op = op; ins_dst = dst;
        ins_s1_rdy = r1; ins_s1_tag = t1; ins_s1_val = v1;
        ins_s2_rdy = r2; ins_s2_tag = t2; ins_s2_val = v2;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned lf;
        idle();
        rst_n = 0;
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        idle(); settle();
        chk("R1 ins_ready after reset", ins_ready, 1);
        chk("R1 iss_valid after reset", iss_valid, 0);
        clk_edge();

        // R2/R4/R7: fill all slots waiting on tag 5, refuse a fifth insert
        for (int k = 0; k < N; k++) begin
            put(OW'(k), TW'(8 + k), 0, 5, 0, 1, 0, DW'(16'h100 + k));
            step();
        end
        put(4'hF, 4'hF, 1, 0, 16'hDEAD, 1, 0, 16'hDEAD);
        settle();
        chk("R2 full pool refuses", ins_ready, 0);
        clk_edge();
        idle(); cdb_valid = 1; cdb_tag = 5; cdb_val = 16'h1234;
        step();
        idle();
        for (int k = 0; k < N; k++) begin
            settle();
            chk("R7 lowest index first", iss_op, k);
            chk("R4 broadcast value captured", iss_v1, 16'h1234);
            clk_edge();
        end
        settle();
        chk("R2 refused insert never issues", iss_valid, 0);
        clk_edge();

        // R6: same-cycle broadcast at insertion
        put(6, 3, 0, 7, 0, 1, 0, 16'h0055);
        cdb_valid = 1; cdb_tag = 7; cdb_val = 16'hAAAA;
        step();
        idle(); settle();
        chk("R6 ready at insertion", iss_valid, 1);
        chk("R6 captured value", iss_v1, 16'hAAAA);
        clk_edge();

        // R4/R5: wrong tag and invalid bus ignored
        put(1, 4, 1, 0, 16'h0011, 0, 3, 0);
        step();
        idle(); cdb_valid = 1; cdb_tag = 2; cdb_val = 16'hBEEF;
        step();
        idle(); cdb_valid = 0; cdb_tag = 3; cdb_val = 16'h7777;
        settle();
        chk("R5 not offered while waiting", iss_valid, 0);
        clk_edge();
        idle(); settle();
        chk("R4 invalid bus ignored", iss_valid, 0);
        cdb_valid = 1; cdb_tag = 3; cdb_val = 16'h3333;
        clk_edge();
        idle(); settle();
        chk("R4 wake after match", iss_valid, 1);
        chk("R4 value on source 2", iss_v2, 16'h3333);
        chk("R3 value on source 1", iss_v1, 16'h0011);
        clk_edge();

        // R9: independent younger instruction passes a waiting one
        put(2, 10, 0, 9, 0, 1, 0, 16'h0001);
        step();
        put(3, 11, 1, 0, 16'h0022, 1, 0, 16'h0033);
        step();
        idle(); settle();
        chk("R9 younger issues first", iss_dst, 11);
        chk("R3 inserted value kept", iss_v2, 16'h0033);
        clk_edge();
        cdb_valid = 1; cdb_tag = 9; cdb_val = 16'h9999;
        settle();
        chk("R9 older still waiting", iss_valid, 0);
        clk_edge();
        idle(); settle();
        chk("R9 older issues after wake", iss_dst, 10);
        clk_edge();

        // R8: backpressure
        put(5, 12, 1, 0, 1, 1, 0, 2);
        step();
        idle(); fu_ready = 0;
        for (int k = 0; k < 3; k++) begin
            settle();
            chk("R8 held under stall", iss_valid, 1);
            chk("R8 same entry", iss_dst, 12);
            clk_edge();
        end
        fu_ready = 1; settle();
        chk("R8 accepted", iss_dst, 12);
        clk_edge();
        settle();
        chk("R8 removed after accept", iss_valid, 0);
        clk_edge();

        // R10: flush
        for (int k = 0; k < 3; k++) begin
            put(OW'(k), TW'(k), 1, 0, DW'(k), 1, 0, DW'(k));
            fu_ready = 0;
            step();
        end
        put(9, 9, 1, 0, 9, 1, 0, 9);
        flush = 1; fu_ready = 1;
        settle();
        chk("R10 no insert during flush", ins_ready, 0);
        chk("R10 no offer during flush", iss_valid, 0);
        clk_edge();
        idle(); settle();
        chk("R10 empty after flush", iss_valid, 0);
        chk("R10 free after flush", ins_ready, 1);
        clk_edge();

        // sweep: pseudo-random traffic over a small tag space
        lf = 32'h1ACE_B00C;
        for (int c = 0; c < 6000; c++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            ins_valid  = lf[0] | lf[1];
            ins_op     = lf[5:2];
            ins_dst    = lf[9:6];
            ins_s1_rdy = lf[10] & lf[11];
            ins_s1_tag = {2'b00, lf[13:12]};
            ins_s2_rdy = lf[25];
            ins_s2_tag = {2'b00, lf[27:26]};
            fu_ready   = lf[14] | lf[15];
            cdb_valid  = lf[16];
            cdb_tag    = {2'b00, lf[18:17]};
            flush      = (lf[24:19] == 6'd0);
            ins_s1_val = lf[31:16];
            ins_s2_val = lf[15:0] ^ 16'h5A5A;
            cdb_val    = lf[23:8];
            step();
        end

        idle();
        step();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule